// File: doc/BRIEF.md
# Segment Table Address Mapper

This block turns a two-part logical address, a segment number plus an offset, into a linear physical address. It holds a small register file of segment descriptors. Each descriptor carries a base address, a segment length, a present flag and a read-only flag. A write port reloads descriptors one at a time, for example when a new process is switched in.

A translate port takes a segment number, an offset and an access type (read or write). One cycle later the block returns either the physical address or a fault code. A legal access maps to base plus offset. Three conditions are rejected:
- an offset at or past the segment length,
- a write to a read-only segment,
- a segment number that is unimplemented or whose entry is absent.

A rejected access never yields an address.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset every descriptor is absent, and rsp_valid, rsp_fault and rsp_paddr are all zero.
- R2: For a present segment where the offset is below the length and the access is allowed, rsp_fault is 0 (no fault) and rsp_paddr equals (base + offset) modulo 2^PA_W.
- R3: An offset greater than or equal to the segment length gives rsp_fault = 1 (bound fault) and rsp_paddr = 0. A length of zero therefore faults every offset.
- R4: A write (req_write = 1) to a read-only segment with an in-range offset gives rsp_fault = 2 (protection fault) and rsp_paddr = 0. A read of the same segment translates normally.
- R5: A segment number of N_SEG or more, or one whose entry is absent, gives rsp_fault = 3 (segment fault) and rsp_paddr = 0, whatever the offset and access type.
- R6: rsp_valid rises exactly one cycle after a cycle with req_valid high. A cycle with req_valid low yields, in the next cycle, rsp_valid = 0, rsp_fault = 0 and rsp_paddr = 0.
- R7: When several faults apply, the segment fault wins over the bound fault, and the bound fault wins over the protection fault.
- R8: With wr_en high, the entry at wr_idx takes the write fields at the clock edge. A translation presented in that same cycle still sees the previous contents. A write with wr_idx of N_SEG or more is discarded and changes no entry.
- R9: Rewriting an entry replaces its base, length, present flag and read-only flag all together, so later translations follow only the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | SEG_W | Entry to write |
| wr_base | input | PA_W | New base address |
| wr_limit | input | OFF_W | New segment length |
| wr_present | input | 1 | New present flag |
| wr_rdonly | input | 1 | New read-only flag |
| req_valid | input | 1 | Translation request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within segment |
| req_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_fault | output | 2 | 0 none, 1 bound, 2 protection, 3 segment |
| rsp_paddr | output | PA_W | Physical address, zero on fault |

## Verification
The only state is the descriptor file, so any corruption in it shows up on the first translation of the affected segment, one cycle after the request:
- a wrong base shows as a shifted rsp_paddr;
- a wrong length shows as a spurious or missing bound fault at the boundary offsets;
- a lost present or read-only flag shows as the wrong fault code.

The stimulus probes the offsets just inside and just at each length. It also checks a write that lands in the same cycle as a translation, and a discarded out-of-range write. For the discarded write, the neighbouring entries are read back through the translate port.

// File: rtl/seg_map_pkg.sv
package seg_map_pkg;

    // Result codes; numeric values are visible on rsp_fault.
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_LIMIT = 2'd1,
        FLT_PROT  = 2'd2,
        FLT_SEG   = 2'd3
    } fault_e;

endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file #(
    parameter int SEG_W = 3,
    parameter int N_SEG = 6,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [OFF_W-1:0] wr_limit,
    input  logic             wr_present,
    input  logic             wr_rdonly,
    input  logic [SEG_W-1:0] rd_idx,
    output logic [PA_W-1:0]  rd_base,
    output logic [OFF_W-1:0] rd_limit,
    output logic             rd_present,
    output logic             rd_rdonly
);

    typedef struct packed {
        logic [PA_W-1:0]  base;
        logic [OFF_W-1:0] limit;
        logic             present;
        logic             rdonly;
    } desc_t;

    desc_t desc_d [N_SEG];
    desc_t desc_q [N_SEG];
    desc_t rd_sel;

    always_comb begin
        for (int i = 0; i < N_SEG; i++) begin
            desc_d[i] = desc_q[i];
            if (wr_en && (int'(wr_idx) == i)) begin
                desc_d[i] = '{base: wr_base, limit: wr_limit,
                              present: wr_present, rdonly: wr_rdonly};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SEG; i++) desc_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_SEG; i++) desc_q[i] <= desc_d[i];
        end
    end

    // Unimplemented numbers read back as an absent, all-zero entry.
    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < N_SEG; i++) begin
            if (int'(rd_idx) == i) rd_sel = desc_q[i];
        end
    end

    assign rd_base    = rd_sel.base;
    assign rd_limit   = rd_sel.limit;
    assign rd_present = rd_sel.present;
    assign rd_rdonly  = rd_sel.rdonly;

    // R8: an in-range write is visible on the read side from the next cycle.
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < N_SEG)) |=>
            ((rd_idx != $past(wr_idx)) ||
             ((rd_base == $past(wr_base)) && (rd_limit == $past(wr_limit)) &&
              (rd_present == $past(wr_present)) && (rd_rdonly == $past(wr_rdonly)))));

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_map_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic [PA_W-1:0]  base,
    input  logic [OFF_W-1:0] limit,
    input  logic             present,
    input  logic             rdonly,
    input  logic [OFF_W-1:0] off,
    input  logic             is_write,
    output fault_e           fault,
    output logic [PA_W-1:0]  paddr
);

    // Priority: missing segment, then bound, then protection.
    always_comb begin
        if (!present) begin
            fault = FLT_SEG;
        end else if (off >= limit) begin
            fault = FLT_LIMIT;
        end else if (is_write && rdonly) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end
        paddr = (fault == FLT_NONE) ? (base + PA_W'(off)) : '0;
    end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_map_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int N_SEG = 6,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [OFF_W-1:0] wr_limit,
    input  logic             wr_present,
    input  logic             wr_rdonly,
    input  logic             req_valid,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic             req_write,
    output logic             rsp_valid,
    output logic [1:0]       rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr
);

    typedef struct packed {
        logic            valid;
        fault_e          fault;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    logic [PA_W-1:0]  rd_base;
    logic [OFF_W-1:0] rd_limit;
    logic             rd_present;
    logic             rd_rdonly;
    fault_e           chk_fault;
    logic [PA_W-1:0]  chk_paddr;
    rsp_t             rsp_d;
    rsp_t             rsp_q;

    seg_desc_file #(
        .SEG_W(SEG_W), .N_SEG(N_SEG), .OFF_W(OFF_W), .PA_W(PA_W)
    ) u_desc (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_base    (wr_base),
        .wr_limit   (wr_limit),
        .wr_present (wr_present),
        .wr_rdonly  (wr_rdonly),
        .rd_idx     (req_seg),
        .rd_base    (rd_base),
        .rd_limit   (rd_limit),
        .rd_present (rd_present),
        .rd_rdonly  (rd_rdonly)
    );

    seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .base     (rd_base),
        .limit    (rd_limit),
        .present  (rd_present),
        .rdonly   (rd_rdonly),
        .off      (req_off),
        .is_write (req_write),
        .fault    (chk_fault),
        .paddr    (chk_paddr)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.fault = chk_fault;
            rsp_d.paddr = chk_paddr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_paddr = rsp_q.paddr;

    // R6: one-cycle latency, quiet output after an idle cycle.
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && (rsp_fault == 2'd0) && (rsp_paddr == '0)));

    // R5: absent or unimplemented segment.
    p_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rd_present) |=> ((rsp_fault == 2'd3) && (rsp_paddr == '0)));

    // R3 and R7: bound check, ahead of protection.
    p_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_present && (req_off >= rd_limit)) |=>
            ((rsp_fault == 2'd1) && (rsp_paddr == '0)));

    // R4: write to read-only segment.
    p_ro_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_present && (req_off < rd_limit) && req_write && rd_rdonly) |=>
            ((rsp_fault == 2'd2) && (rsp_paddr == '0)));

    // R2: legal access maps to base plus offset.
    p_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_present && (req_off < rd_limit) && !(req_write && rd_rdonly)) |=>
            ((rsp_fault == 2'd0) &&
             (rsp_paddr == PA_W'($past(rd_base) + PA_W'($past(req_off))))));

endmodule

// File: tb/seg_xlate_top_tb.sv
`timescale 1ns/1ps
module seg_xlate_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [15:0] wr_base = '0;
    logic [11:0] wr_limit = '0;
    logic        wr_present = 1'b0;
    logic        wr_rdonly = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic [11:0] req_off = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_fault;
    logic [15:0] rsp_paddr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    seg_xlate_top #(.SEG_W(3), .N_SEG(6), .OFF_W(12), .PA_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_limit(wr_limit),
        .wr_present(wr_present), .wr_rdonly(wr_rdonly),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    // {seg[2:0], off[11:0], write, fault[1:0], paddr[15:0]}
    localparam int NV = 13;
    localparam logic [33:0] VEC [NV] = '{
        {3'd0, 12'h000, 1'b0, 2'd0, 16'h1000},  // R2 base
        {3'd0, 12'h0FF, 1'b1, 2'd0, 16'h10FF},  // R2 last legal offset
        {3'd0, 12'h100, 1'b0, 2'd1, 16'h0000},  // R3 offset == length
        {3'd1, 12'h01F, 1'b0, 2'd0, 16'h401F},  // R4 read of read-only
        {3'd1, 12'h010, 1'b1, 2'd2, 16'h0000},  // R4 write to read-only
        {3'd1, 12'h020, 1'b1, 2'd1, 16'h0000},  // R7 bound over protection
        {3'd2, 12'h180, 1'b0, 2'd0, 16'h0080},  // R2 wrap-around
        {3'd3, 12'h000, 1'b0, 2'd3, 16'h0000},  // R5 absent
        {3'd6, 12'h000, 1'b1, 2'd3, 16'h0000},  // R5 unimplemented
        {3'd7, 12'hFFF, 1'b1, 2'd3, 16'h0000},  // R7 segment over bound/protection
        {3'd4, 12'h000, 1'b0, 2'd1, 16'h0000},  // R3 zero length
        {3'd5, 12'hFFE, 1'b1, 2'd0, 16'h8FFE},  // R2 high offset
        {3'd5, 12'hFFF, 1'b0, 2'd1, 16'h0000}   // R3 offset == length
    };

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(input string tag, input logic ev, input logic [1:0] ef,
                         input logic [15:0] ea);
        checks++;
        if (rsp_valid !== ev || rsp_fault !== ef || rsp_paddr !== ea) begin
            errors++;
            $display("FAIL %s: got valid=%0b fault=%0d paddr=%h, expected valid=%0b fault=%0d paddr=%h",
                     tag, rsp_valid, rsp_fault, rsp_paddr, ev, ef, ea);
        end
    endtask

    task automatic wr_desc(input logic [2:0] idx, input logic [15:0] b,
                           input logic [11:0] l, input logic p, input logic ro);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_base = b; wr_limit = l;
        wr_present = p; wr_rdonly = ro;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic xlate(input logic [2:0] s, input logic [11:0] o, input logic w,
                         input string tag, input logic [1:0] ef, input logic [15:0] ea);
        @(negedge clk);
        req_valid = 1'b1; req_seg = s; req_off = o; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, 1'b1, ef, ea);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R6: watchdog expired, got no end, expected end of run");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", 1'b0, 2'd0, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", 1'b0, 2'd0, 16'h0000);
        xlate(3'd0, 12'h000, 1'b0, "R1 entry absent after reset", 2'd3, 16'h0000);

        wr_desc(3'd0, 16'h1000, 12'h100, 1'b1, 1'b0);
        wr_desc(3'd1, 16'h4000, 12'h020, 1'b1, 1'b1);
        wr_desc(3'd2, 16'hFF00, 12'h200, 1'b1, 1'b0);
        wr_desc(3'd4, 16'h0200, 12'h000, 1'b1, 1'b1);
        wr_desc(3'd5, 16'h8000, 12'hFFF, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            case (VEC[i][17:16])
                2'd0: tag = "R2";
                2'd1: tag = "R3";
                2'd2: tag = "R4";
                default: tag = "R5";
            endcase
            if (i == 5 || i == 9) tag = "R7";
            xlate(VEC[i][33:31], VEC[i][30:19], VEC[i][18],
                  $sformatf("%s vector %0d", tag, i), VEC[i][17:16], VEC[i][15:0]);
        end

        // R6: idle cycle clears the response.
        @(negedge clk);
        check("R6 idle after request", 1'b0, 2'd0, 16'h0000);

        // R8: write and translate in the same cycle; old contents used.
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd0; wr_base = 16'h2000; wr_limit = 12'h040;
        wr_present = 1'b1; wr_rdonly = 1'b1;
        req_valid = 1'b1; req_seg = 3'd0; req_off = 12'h010; req_write = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R8 same-cycle write sees old entry", 1'b1, 2'd0, 16'h1010);

        // R9: all fields replaced.
        xlate(3'd0, 12'h010, 1'b0, "R9 new base", 2'd0, 16'h2010);
        xlate(3'd0, 12'h010, 1'b1, "R9 new read-only flag", 2'd2, 16'h0000);
        xlate(3'd0, 12'h050, 1'b0, "R9 new length", 2'd1, 16'h0000);

        // R8: write to unimplemented index is discarded.
        wr_desc(3'd6, 16'h7777, 12'hFFF, 1'b1, 1'b0);
        xlate(3'd6, 12'h000, 1'b0, "R8 discarded write, seg 6", 2'd3, 16'h0000);
        xlate(3'd5, 12'h000, 1'b0, "R8 discarded write, seg 5 intact", 2'd0, 16'h8000);
        xlate(3'd0, 12'h001, 1'b0, "R8 discarded write, seg 0 intact", 2'd0, 16'h2001);

        // R5: entry cleared by rewriting it absent.
        wr_desc(3'd5, 16'h8000, 12'hFFF, 1'b0, 1'b0);
        xlate(3'd5, 12'h000, 1'b0, "R5 entry made absent", 2'd3, 16'h0000);

        @(negedge clk);
        finish_run();
    end

endmodule